// File: doc/BRIEF.md
# Root Port PME Status and Wake Sequencer

This block holds the power-management event (PME) status of a root port together with the enable that gates its interrupt. A downstream requester reports a PME by presenting its bus, device and function numbers for one cycle. The block packs them into a 16-bit requester ID and latches it into a 32-bit status word. It then raises a status flag and, if software has enabled it, pulses a PME interrupt request. A second report that arrives before software acknowledges the first is parked in a one-entry holding slot, and a pending flag is set. Software acknowledges by writing one to the status flag. If a report is parked, the acknowledge promotes it: the status stays set and a new interrupt request is issued. If nothing is parked, the acknowledge clears the status.

The block also sequences hot-plug interrupts against low power. When a hot-plug event occurs while the port sits in D3 with PME interrupts enabled, the hot-plug interrupt is held back and the port reports a PME under its own requester ID to wake the host. The held-back hot-plug interrupt is issued when software clears the PME status with nothing parked. Register writes come through a simple byte-enabled write port. Both registers are visible at all times on output ports.

Top module: `pme_root_status`

## Requirements
- R1: A cycle with `rst_n` low sets status word and control word to zero, empties the holding slot, drops any held-back hot-plug interrupt, and holds both interrupt outputs low.
- R2: Status word layout: bits 15:0 carry the requester ID = bus<<8 | device<<3 | function; bit 16 is the PME status flag; bit 17 is the pending flag; bits 31:18 read zero.
- R3: A PME report that finds the status flag clear loads its requester ID into bits 15:0 and sets bit 16.
- R4: A PME report that finds the status flag set leaves bits 16:0 unchanged, sets bit 17 and stores the ID in the holding slot; a later report replaces the stored ID.
- R5: A write with bit 16 set to the status word while bit 17 is set loads the stored ID into bits 15:0, keeps bit 16 set, clears bit 17 and requests a PME interrupt.
- R6: A write with bit 16 set to the status word while bit 17 is clear clears bit 16 and keeps bits 15:0; a status write with bit 16 clear changes nothing.
- R7: `pme_irq` is high for the cycle after an edge at which a report or a promotion loads the ID field, and only if control bit 3 (PME interrupt enable) was set before that edge.
- R8: A hot-plug event while not (`d3_state` high and control bit 3 set) pulses `hp_irq` in the cycle after the edge.
- R9: A hot-plug event while `d3_state` is high and control bit 3 is set gives no `hp_irq`, marks the hot-plug interrupt as held back and reports a PME with the port's own ID (parameters `PORT_BUS`, `PORT_DEV`, `PORT_FN`; by default ID 0x00E0) by the R3/R4 rules.
- R10: A status write that clears bit 16 under R6 while a hot-plug interrupt is held back pulses `hp_irq` in the next cycle and drops the hold.
- R11: A status write takes effect only with `wr_be` = 4'b1111. A control write takes effect only with `wr_be` = 4'b0011 and loads `wr_data[15:0]`. Other byte-enable patterns are ignored. `wr_sel` = 0 addresses control and 1 addresses status.
- R12: Within one cycle the write is applied first, then an external PME report, then the hot-plug event. Control bit 3 and `d3_state` are taken as they were before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pme_valid | input | 1 | External PME report this cycle |
| pme_bus | input | 8 | Requester bus number |
| pme_dev | input | 5 | Requester device number |
| pme_fn | input | 3 | Requester function number |
| hp_event | input | 1 | Hot-plug interrupt condition this cycle |
| d3_state | input | 1 | Port is in D3 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = status word |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| root_sts | output | 32 | Status word |
| root_ctl | output | 16 | Control word |
| pme_irq | output | 1 | PME interrupt request pulse |
| hp_irq | output | 1 | Hot-plug interrupt request pulse |

## Verification
Every result of this block is registered once. A report, hot-plug event or write driven before a rising edge shows in `root_sts`, `root_ctl`, `pme_irq` and `hp_irq` right after that edge, and each interrupt pulse lasts that one cycle only. The bench drives inputs on the falling edge. It updates its reference state at the rising edge and compares all four outputs on the following falling edge, so each check lands exactly one edge after its stimulus. Directed sequences cover promotion, held-back hot-plug release, ignored byte-enable patterns and same-cycle ordering; seeded random traffic then mixes all of them.

// File: rtl/pme_root_status_pkg.sv
// Package: shared widths, bit positions and write encodings of the
// root PME status block. Assumes an 8/5/3 bus/device/function split.
package pme_root_status_pkg;
    localparam int BUS_W      = 8;
    localparam int DEV_W      = 5;
    localparam int FN_W       = 3;
    localparam int RID_W      = BUS_W + DEV_W + FN_W;
    localparam int STS_W      = 32;
    localparam int CTL_W      = 16;
    localparam int BE_W       = STS_W / 8;
    localparam int STS_PME    = 16;
    localparam int STS_PEND   = 17;
    localparam int CTL_PMEEN  = 3;
    localparam logic [BE_W-1:0] BE_STS = 4'b1111;
    localparam logic [BE_W-1:0] BE_CTL = 4'b0011;
    localparam logic SEL_CTL = 1'b0;
    localparam logic SEL_STS = 1'b1;

    typedef logic [RID_W-1:0] rid_t;
endpackage

// File: rtl/pme_rid_fmt.sv
// Module: packs bus, device and function numbers into a requester ID.
// Assumes the three fields together fill the ID width exactly.
module pme_rid_fmt
    import pme_root_status_pkg::*;
#(
    parameter int B_W = BUS_W,
    parameter int D_W = DEV_W,
    parameter int F_W = FN_W,
    localparam int R_W = B_W + D_W + F_W
) (
    input  logic [B_W-1:0] bus,
    input  logic [D_W-1:0] dev,
    input  logic [F_W-1:0] fn,
    output logic [R_W-1:0] rid
);
    // Shift each field to its place and merge.
    always_comb begin
        rid = (R_W'(bus) << (D_W + F_W)) | (R_W'(dev) << F_W) | R_W'(fn);
    end
endmodule

// File: rtl/pme_ctl_reg.sv
// Module: root control word. Loads only on a whole-word write with
// the low two byte enables set. Exposes the PME interrupt enable bit.
module pme_ctl_reg
    import pme_root_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [STS_W-1:0] wr_data,
    output logic [CTL_W-1:0] ctl_q,
    output logic             pme_en
);
    logic ctl_wr;

    // Decode a well-formed control write.
    always_comb begin
        ctl_wr = wr_en && (wr_sel == SEL_CTL) && (wr_be == BE_CTL);
    end

    // Hold the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_wr) ctl_q <= wr_data[CTL_W-1:0];
    end

    assign pme_en = ctl_q[CTL_PMEEN];

    // R11: a control write with any other byte-enable pattern leaves the word unchanged
    a_r11_ctl_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTL && wr_be != BE_CTL) |=> $stable(ctl_q));
endmodule

// File: rtl/pme_pend_buf.sv
// Module: one-entry holding slot for a requester ID. Pop and push in
// the same cycle leave it full with the pushed ID. Assumes pop only
// when full.
module pme_pend_buf
    import pme_root_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  rid_t push_id,
    input  logic pop,
    output logic full,
    output rid_t held_id
);
    // Track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n)   full <= 1'b0;
        else if (push) full <= 1'b1;
        else if (pop)  full <= 1'b0;
    end

    // Capture the newest ID; no reset needed on the data path.
    always_ff @(posedge clk) begin
        if (push) held_id <= push_id;
    end

    // R5: a promotion only ever takes an entry that exists
    a_r5_pop_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> full);
endmodule

// File: rtl/pme_core.sv
// Module: PME status flag, ID field, held-back hot-plug flag and the
// two interrupt pulses. Applies per cycle: write, external report,
// then hot-plug. Enable and D3 are the values before the edge.
module pme_core
    import pme_root_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [STS_W-1:0] wr_data,
    input  logic             ext_valid,
    input  rid_t             ext_id,
    input  rid_t             own_id,
    input  logic             hp_event,
    input  logic             d3_state,
    input  logic             pme_en,
    input  logic             buf_full,
    input  rid_t             buf_id,
    output logic             buf_push,
    output rid_t             buf_push_id,
    output logic             buf_pop,
    output logic             sts_q,
    output rid_t             rid_q,
    output logic             pme_irq,
    output logic             hp_irq
);
    logic sts_ack;
    logic wake;
    logic defer_q;
    logic sts_n;
    logic defer_n;
    logic fire;
    logic hp_n;
    rid_t rid_n;

    // Decode an acknowledge: whole-dword status write with the flag bit set.
    always_comb begin
        sts_ack = wr_en && (wr_sel == SEL_STS) && (wr_be == BE_STS) && wr_data[STS_PME];
        wake    = d3_state && pme_en;
    end

    // Next-state in the fixed order write, external report, hot-plug.
    always_comb begin
        sts_n       = sts_q;
        rid_n       = rid_q;
        defer_n     = defer_q;
        fire        = 1'b0;
        hp_n        = 1'b0;
        buf_push    = 1'b0;
        buf_push_id = buf_id;
        buf_pop     = 1'b0;
        if (sts_ack) begin
            if (buf_full) begin
                rid_n   = buf_id;
                buf_pop = 1'b1;
                fire    = 1'b1;
            end else begin
                sts_n = 1'b0;
                if (defer_q) begin
                    hp_n    = 1'b1;
                    defer_n = 1'b0;
                end
            end
        end
        if (ext_valid) begin
            if (sts_n) begin
                buf_push    = 1'b1;
                buf_push_id = ext_id;
            end else begin
                rid_n = ext_id;
                sts_n = 1'b1;
                fire  = 1'b1;
            end
        end
        if (hp_event) begin
            if (wake) begin
                defer_n = 1'b1;
                if (sts_n) begin
                    buf_push    = 1'b1;
                    buf_push_id = own_id;
                end else begin
                    rid_n = own_id;
                    sts_n = 1'b1;
                    fire  = 1'b1;
                end
            end else begin
                hp_n = 1'b1;
            end
        end
    end

    // Register status, ID field, hold flag and interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q   <= 1'b0;
            rid_q   <= '0;
            defer_q <= 1'b0;
            pme_irq <= 1'b0;
            hp_irq  <= 1'b0;
        end else begin
            sts_q   <= sts_n;
            rid_q   <= rid_n;
            defer_q <= defer_n;
            pme_irq <= fire && pme_en;
            hp_irq  <= hp_n;
        end
    end

    // R4: a parked report implies the status flag is set
    a_r4_pending_has_status: assert property (@(posedge clk) disable iff (!rst_n)
        buf_full |-> sts_q);
    // R7: an interrupt pulse only with status set and the enable set before
    a_r7_pme_gated: assert property (@(posedge clk) disable iff (!rst_n)
        pme_irq |-> (sts_q && $past(pme_en)));
    // R9: a hot-plug hold only starts from a hot-plug event in the wake state
    a_r9_hold_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(defer_q) |-> $past(hp_event && wake));
    // R8 and R10: every hot-plug pulse has a direct or a released cause
    a_r8_hp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        hp_irq |-> ($past(hp_event && !wake) || $past(defer_q && sts_ack && !buf_full)));
endmodule

// File: rtl/pme_root_status.sv
// Module: top of the root PME status block. Formats the incoming and
// the port's own requester IDs, holds control, the holding slot and
// the status core, and assembles the status word.
module pme_root_status
    import pme_root_status_pkg::*;
#(
    parameter logic [BUS_W-1:0] PORT_BUS = 8'd0,
    parameter logic [DEV_W-1:0] PORT_DEV = 5'd28,
    parameter logic [FN_W-1:0]  PORT_FN  = 3'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pme_valid,
    input  logic [BUS_W-1:0] pme_bus,
    input  logic [DEV_W-1:0] pme_dev,
    input  logic [FN_W-1:0]  pme_fn,
    input  logic             hp_event,
    input  logic             d3_state,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BE_W-1:0]  wr_be,
    input  logic [STS_W-1:0] wr_data,
    output logic [STS_W-1:0] root_sts,
    output logic [CTL_W-1:0] root_ctl,
    output logic             pme_irq,
    output logic             hp_irq
);
    rid_t ext_id;
    rid_t own_id;
    rid_t buf_id;
    rid_t push_id;
    rid_t rid_q;
    logic pme_en;
    logic buf_full;
    logic push;
    logic pop;
    logic sts_q;

    pme_rid_fmt u_ext_fmt (.bus(pme_bus), .dev(pme_dev), .fn(pme_fn), .rid(ext_id));
    pme_rid_fmt u_own_fmt (.bus(PORT_BUS), .dev(PORT_DEV), .fn(PORT_FN), .rid(own_id));

    pme_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_be(wr_be), .wr_data(wr_data), .ctl_q(root_ctl), .pme_en(pme_en)
    );

    pme_pend_buf u_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .push_id(push_id),
        .pop(pop), .full(buf_full), .held_id(buf_id)
    );

    pme_core u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_be(wr_be), .wr_data(wr_data), .ext_valid(pme_valid),
        .ext_id(ext_id), .own_id(own_id), .hp_event(hp_event),
        .d3_state(d3_state), .pme_en(pme_en), .buf_full(buf_full),
        .buf_id(buf_id), .buf_push(push), .buf_push_id(push_id),
        .buf_pop(pop), .sts_q(sts_q), .rid_q(rid_q),
        .pme_irq(pme_irq), .hp_irq(hp_irq)
    );

    // Assemble the status word; unused bits read zero.
    always_comb begin
        root_sts           = '0;
        root_sts[RID_W-1:0] = rid_q;
        root_sts[STS_PME]  = sts_q;
        root_sts[STS_PEND] = buf_full;
    end

    // R6: an acknowledge with nothing parked leaves the flag clear afterwards
    a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_STS && wr_be == BE_STS && wr_data[STS_PME]
         && !buf_full && !pme_valid && !hp_event) |=> !root_sts[STS_PME]);
endmodule

// File: tb/pme_root_status_bench.sv
module pme_root_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pme_valid = 1'b0;
    logic [7:0]  pme_bus = '0;
    logic [4:0]  pme_dev = '0;
    logic [2:0]  pme_fn = '0;
    logic        hp_event = 1'b0;
    logic        d3_state = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] root_sts;
    logic [15:0] root_ctl;
    logic        pme_irq;
    logic        hp_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [15:0] OWN_ID = 16'h00E0;

    // reference state
    logic        m_sts, m_pend, m_hold, m_pirq, m_hirq;
    logic [15:0] m_rid, m_buf, m_ctl;

    pme_root_status u_pme_root_status (.*);

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cycles++;

    function automatic logic [15:0] fmt_id(logic [7:0] b, logic [4:0] d, logic [2:0] f);
        return {b, d, f};
    endfunction

    function automatic logic [31:0] m_word();
        return {14'd0, m_pend, m_sts, m_rid};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sts = 0; m_pend = 0; m_hold = 0; m_pirq = 0; m_hirq = 0;
        m_rid = 0; m_buf = 0; m_ctl = 0;
    endtask

    // reference update for one edge, written from R3..R12
    task automatic model_edge();
        logic en, wake, fire, hp;
        en = m_ctl[3]; wake = d3_state && en; fire = 0; hp = 0;
        if (wr_en && wr_sel == 1'b0 && wr_be == 4'b0011) m_ctl = wr_data[15:0];
        if (wr_en && wr_sel == 1'b1 && wr_be == 4'b1111 && wr_data[16]) begin
            if (m_pend) begin m_rid = m_buf; m_pend = 0; fire = 1; end
            else begin m_sts = 0; if (m_hold) begin hp = 1; m_hold = 0; end end
        end
        if (pme_valid) begin
            if (m_sts) begin m_pend = 1; m_buf = fmt_id(pme_bus, pme_dev, pme_fn); end
            else begin m_rid = fmt_id(pme_bus, pme_dev, pme_fn); m_sts = 1; fire = 1; end
        end
        if (hp_event) begin
            if (wake) begin
                m_hold = 1;
                if (m_sts) begin m_pend = 1; m_buf = OWN_ID; end
                else begin m_rid = OWN_ID; m_sts = 1; fire = 1; end
            end else hp = 1;
        end
        m_pirq = fire && en;
        m_hirq = hp;
    endtask

    task automatic compare_all(string tag);
        check({tag, " sts"}, root_sts, m_word());
        check({tag, " ctl"}, {16'd0, root_ctl}, {16'd0, m_ctl});
        check({tag, " pme_irq"}, {31'd0, pme_irq}, {31'd0, m_pirq});
        check({tag, " hp_irq"}, {31'd0, hp_irq}, {31'd0, m_hirq});
    endtask

    // one cycle: inputs already set at negedge; model at posedge; compare at negedge
    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_en = 0; pme_valid = 0; hp_event = 0;
        compare_all(tag);
    endtask

    task automatic do_write(logic sel, logic [3:0] be, logic [31:0] d, string tag);
        wr_en = 1; wr_sel = sel; wr_be = be; wr_data = d;
        step(tag);
    endtask

    task automatic do_pme(logic [7:0] b, logic [4:0] d, logic [2:0] f, string tag);
        pme_valid = 1; pme_bus = b; pme_dev = d; pme_fn = f;
        step(tag);
    endtask

    task automatic do_hp(logic d3, string tag);
        hp_event = 1; d3_state = d3;
        step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected<200000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare_all("R1 reset");
        rst_n = 1;
        @(negedge clk);

        // R11 control write forms
        do_write(1'b0, 4'b0011, 32'h0000_0008, "R11 ctl word");
        check("R11 ctl value", {16'd0, root_ctl}, 32'h0000_0008);
        do_write(1'b0, 4'b1111, 32'h0000_0000, "R11 ctl dword ignored");
        check("R11 ctl kept", {16'd0, root_ctl}, 32'h0000_0008);

        // R2 R3 R7 first report
        do_pme(8'h12, 5'd3, 3'd5, "R3 load");
        check("R2 layout", root_sts, 32'h0001_121D);
        check("R7 pulse", {31'd0, pme_irq}, 32'd1);
        step("R7 one cycle");
        check("R7 pulse ends", {31'd0, pme_irq}, 32'd0);

        // R4 park, latest wins
        do_pme(8'h77, 5'd2, 3'd2, "R4 park");
        do_pme(8'h34, 5'd1, 3'd1, "R4 replace");
        check("R4 pending word", root_sts, 32'h0003_121D);

        // R11 partial status write, R6 write with flag bit clear
        do_write(1'b1, 4'b0011, 32'h0001_0000, "R11 sts partial ignored");
        check("R11 sts kept", root_sts, 32'h0003_121D);
        do_write(1'b1, 4'b1111, 32'h0000_FFFF, "R6 zero bit no effect");
        check("R6 sts kept", root_sts, 32'h0003_121D);

        // R5 promotion
        do_write(1'b1, 4'b1111, 32'h0001_0000, "R5 promote");
        check("R5 word", root_sts, 32'h0001_3409);
        check("R5 irq", {31'd0, pme_irq}, 32'd1);

        // R6 clear
        do_write(1'b1, 4'b1111, 32'h0001_0000, "R6 clear");
        check("R6 word", root_sts, 32'h0000_3409);

        // R8 direct hot-plug
        do_hp(1'b0, "R8 direct");
        check("R8 hp_irq", {31'd0, hp_irq}, 32'd1);

        // R9 held back in D3
        do_hp(1'b1, "R9 hold");
        check("R9 no hp", {31'd0, hp_irq}, 32'd0);
        check("R9 own id", root_sts, {16'h0001, OWN_ID});

        // R10 release
        do_write(1'b1, 4'b1111, 32'h0001_0000, "R10 release");
        check("R10 hp_irq", {31'd0, hp_irq}, 32'd1);
        d3_state = 0;

        // R7 disabled enable, R8 in D3 without enable
        do_write(1'b0, 4'b0011, 32'h0, "R7 disable");
        do_pme(8'h01, 5'd1, 3'd1, "R7 gated");
        check("R7 no irq", {31'd0, pme_irq}, 32'd0);
        do_hp(1'b1, "R8 d3 no enable");
        check("R8 hp d3", {31'd0, hp_irq}, 32'd1);
        d3_state = 0;

        // R12 same cycle: acknowledge then report
        do_write(1'b0, 4'b0011, 32'h8, "R12 enable");
        wr_en = 1; wr_sel = 1; wr_be = 4'hF; wr_data = 32'h0001_0000;
        pme_valid = 1; pme_bus = 8'hAB; pme_dev = 5'd7; pme_fn = 3'd6;
        step("R12 ack+report");
        check("R12 word", root_sts, {16'h0001, fmt_id(8'hAB, 5'd7, 3'd6)});

        // random traffic
        void'($urandom(32'd1357));
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 9));
            wr_en = ($urandom_range(0, 9) < 3);
            wr_sel = 1'($urandom_range(0, 1));
            wr_be = (r < 4) ? 4'hF : (r < 7) ? 4'h3 : 4'($urandom);
            wr_data = $urandom;
            pme_valid = ($urandom_range(0, 9) < 3);
            pme_bus = 8'($urandom); pme_dev = 5'($urandom); pme_fn = 3'($urandom);
            hp_event = ($urandom_range(0, 9) == 0);
            d3_state = ($urandom_range(0, 3) != 0);
            step("R12 random");
        end

        rst_n = 0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        compare_all("R1 mid reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule